// File: doc/BRIEF.md
# Adjacent Key-Wire Duplicate Suppressor

A single track crossing a wire chamber often raises a candidate on two or more neighbouring key wires at once. This block takes the per-key-wire candidate qualities of two independent track classes, accelerator-like and collision-like, and removes these duplicates. It keeps the candidate that wins against its immediate neighbours and sets the losers to quality zero. Each wire also carries the time bin in which its candidate first appeared. Two neighbours are treated as the same track only when their first bins lie within a programmable depth of each other.

A start pulse loads the quality arrays, the first-bin array and the depth. The block then walks the key wires twice, one wire per clock. The first pass decides for every wire whether it must be cancelled and stores that decision as a flag. The second pass zeroes every flagged wire. Because no wire is cleared until every flag has been decided, a wire that is itself cancelled can still cancel its neighbour. A build-time parameter selects a compact comparison variant. In that variant only the low two bits of a neighbour's quality are compared, and the tie rule is mirrored.

Top module: `ghost_cancel`

## Requirements
- R1: After reset, both quality outputs are all zero and done_o is low.
- R2: In the default variant, a non-zero wire is cancelled (its output quality becomes zero) when the wire directly below it (index minus one) has a non-zero quality greater than or equal to its own. Cancellation only ever sets a quality to zero.
- R3: In the default variant, the wire directly above (index plus one) cancels the current wire only when its quality is strictly greater. On a tie the upper wire does not cancel.
- R4: A wire whose quality is zero is never tested and never cancels a neighbour. Wire 0 has no lower neighbour and the last wire has no upper neighbour; the missing neighbour counts as quality zero.
- R5: All cancel decisions are taken on the loaded qualities before any wire is cleared. A wire that is cancelled still cancels its own neighbour.
- R6: The accelerator class and the collision class are processed independently. A candidate in one class never affects the other class.
- R7: A neighbour may cancel only when the absolute difference between its first time bin and the current wire's first time bin is at most depth_i.
- R8: With COMPACT=1, a neighbour's quality is masked to its low 2 bits before comparison. The lower neighbour then needs a strictly greater value, and the upper neighbour needs a value greater than or equal.
- R9: done_o rises exactly 2*N_WIRES clock cycles after the edge that accepts start_i. It then stays high with stable outputs until the next accepted start.
- R10: start_i is accepted only when no run is in progress. A start pulse during a run is ignored, and that run's result and timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load the inputs and begin a run |
| depth_i | input | BX_W | Largest first-bin distance at which neighbours interact |
| q_acc_i | input | N_WIRES*Q_W | Accelerator qualities, wire w at bits [w*Q_W +: Q_W] |
| q_col_i | input | N_WIRES*Q_W | Collision qualities, same packing |
| bx_i | input | N_WIRES*BX_W | First time bin per wire, wire w at bits [w*BX_W +: BX_W] |
| q_acc_o | output | N_WIRES*Q_W | Cleaned accelerator qualities |
| q_col_o | output | N_WIRES*Q_W | Cleaned collision qualities |
| done_o | output | 1 | Run complete; outputs valid |

## Verification
The block has a single result per run. The cleaned arrays and done_o become valid 2*N_WIRES edges after the accepting edge: N_WIRES for the flag pass and N_WIRES for the clearing pass. The bench drives on falling edges and counts falling edges from the accepting edge until done_o is seen. It requires that count to equal 2*N_WIRES, then compares both quality outputs against a bench-side model of the rules. After done_o, further idle cycles are sampled to confirm the result holds. During a run, the outputs are checked only for showing intermediate, zero-only changes.

// File: rtl/gc_pkg.sv
package gc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_APPLY = 2'd2,
    ST_FIN   = 2'd3
  } gc_state_e;

  localparam int unsigned N_CLASS = 2;
endpackage

// File: rtl/gc_cmp.sv
module gc_cmp #(
  parameter int unsigned Q_W     = 3,
  parameter int unsigned BX_W    = 4,
  parameter bit          COMPACT = 1'b0
) (
  input  logic [Q_W-1:0]  cur_q_i,
  input  logic [Q_W-1:0]  prev_q_i,
  input  logic [Q_W-1:0]  next_q_i,
  input  logic [BX_W-1:0] cur_bx_i,
  input  logic [BX_W-1:0] prev_bx_i,
  input  logic [BX_W-1:0] next_bx_i,
  input  logic [BX_W-1:0] depth_i,
  output logic            kill_o
);
  localparam logic [Q_W-1:0] LOW_MASK = Q_W'(3);

  logic [BX_W-1:0] d_prev, d_next;
  logic            lower_win, upper_win;
  logic            prev_ok, next_ok;

  assign d_prev = (cur_bx_i >= prev_bx_i) ? cur_bx_i - prev_bx_i : prev_bx_i - cur_bx_i;
  assign d_next = (cur_bx_i >= next_bx_i) ? cur_bx_i - next_bx_i : next_bx_i - cur_bx_i;

  generate
    if (COMPACT) begin : g_compact
      logic [Q_W-1:0] prev_m, next_m;
      assign prev_m    = prev_q_i & LOW_MASK;
      assign next_m    = next_q_i & LOW_MASK;
      assign lower_win = prev_m > cur_q_i;
      assign upper_win = next_m >= cur_q_i;
    end else begin : g_full
      assign lower_win = prev_q_i >= cur_q_i;
      assign upper_win = next_q_i > cur_q_i;
    end
  endgenerate

  assign prev_ok = (prev_q_i != '0) && (d_prev <= depth_i) && lower_win;
  assign next_ok = (next_q_i != '0) && (d_next <= depth_i) && upper_win;
  assign kill_o  = (cur_q_i != '0) && (prev_ok || next_ok);
endmodule

// File: rtl/gc_ctrl.sv
module gc_ctrl
  import gc_pkg::*;
#(
  parameter int unsigned N_WIRES = 8,
  localparam int unsigned IDX_W  = (N_WIRES > 1) ? $clog2(N_WIRES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output gc_state_e        state_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             load_o,
  output logic             busy_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_WIRES - 1);
  localparam logic [IDX_W-1:0] ONE  = IDX_W'(1);

  assign busy_o = (state_o == ST_SCAN) || (state_o == ST_APPLY);
  assign load_o = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_IDLE;
      idx_o   <= '0;
    end else begin
      case (state_o)
        ST_SCAN: begin
          if (idx_o == LAST) begin
            state_o <= ST_APPLY;
            idx_o   <= '0;
          end else begin
            idx_o <= idx_o + ONE;
          end
        end
        ST_APPLY: begin
          if (idx_o == LAST) begin
            state_o <= ST_FIN;
            idx_o   <= '0;
          end else begin
            idx_o <= idx_o + ONE;
          end
        end
        default: begin
          if (start_i) begin
            state_o <= ST_SCAN;
            idx_o   <= '0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ghost_cancel.sv
module ghost_cancel
  import gc_pkg::*;
#(
  parameter int unsigned N_WIRES = 8,
  parameter int unsigned Q_W     = 3,
  parameter int unsigned BX_W    = 4,
  parameter bit          COMPACT = 1'b0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [BX_W-1:0]         depth_i,
  input  logic [N_WIRES*Q_W-1:0]  q_acc_i,
  input  logic [N_WIRES*Q_W-1:0]  q_col_i,
  input  logic [N_WIRES*BX_W-1:0] bx_i,
  output logic [N_WIRES*Q_W-1:0]  q_acc_o,
  output logic [N_WIRES*Q_W-1:0]  q_col_o,
  output logic                    done_o
);
  localparam int unsigned     IDX_W = (N_WIRES > 1) ? $clog2(N_WIRES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_WIRES - 1);
  localparam logic [IDX_W-1:0] ONE  = IDX_W'(1);

  gc_state_e        state;
  logic [IDX_W-1:0] idx;
  logic             load;
  logic             busy;

  logic [N_CLASS-1:0][N_WIRES-1:0][Q_W-1:0] q_r;
  logic [N_CLASS-1:0][N_WIRES-1:0]          flag_r;
  logic [N_WIRES-1:0][BX_W-1:0]             bx_r;
  logic [BX_W-1:0]                          depth_r;
  logic [N_CLASS-1:0]                       kill;

  logic [BX_W-1:0] cur_bx, prev_bx, next_bx;

  gc_ctrl #(.N_WIRES(N_WIRES)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .state_o (state),
    .idx_o   (idx),
    .load_o  (load),
    .busy_o  (busy)
  );

  assign cur_bx  = bx_r[idx];
  assign prev_bx = (idx == '0)  ? '0 : bx_r[idx - ONE];
  assign next_bx = (idx == LAST) ? '0 : bx_r[idx + ONE];

  generate
    for (genvar c = 0; c < N_CLASS; c++) begin : g_class
      logic [Q_W-1:0] cur_q, prev_q, next_q;
      // missing neighbours at the array edges read as empty
      assign cur_q  = q_r[c][idx];
      assign prev_q = (idx == '0)  ? '0 : q_r[c][idx - ONE];
      assign next_q = (idx == LAST) ? '0 : q_r[c][idx + ONE];

      gc_cmp #(.Q_W(Q_W), .BX_W(BX_W), .COMPACT(COMPACT)) u_cmp (
        .cur_q_i   (cur_q),
        .prev_q_i  (prev_q),
        .next_q_i  (next_q),
        .cur_bx_i  (cur_bx),
        .prev_bx_i (prev_bx),
        .next_bx_i (next_bx),
        .depth_i   (depth_r),
        .kill_o    (kill[c])
      );
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_r     <= '0;
      flag_r  <= '0;
      bx_r    <= '0;
      depth_r <= '0;
    end else if (load) begin
      q_r[0]  <= q_acc_i;
      q_r[1]  <= q_col_i;
      bx_r    <= bx_i;
      depth_r <= depth_i;
      flag_r  <= '0;
    end else if (state == ST_SCAN) begin
      for (int c = 0; c < N_CLASS; c++) flag_r[c][idx] <= kill[c];
    end else if (state == ST_APPLY) begin
      for (int c = 0; c < N_CLASS; c++)
        if (flag_r[c][idx]) q_r[c][idx] <= '0;
    end
  end

  assign q_acc_o = q_r[0];
  assign q_col_o = q_r[1];
  assign done_o  = (state == ST_FIN);
endmodule

// File: rtl/gc_chk.sv
module gc_chk #(
  parameter int unsigned N_WIRES = 8,
  parameter int unsigned Q_W     = 3
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   start_i,
  input logic                   busy_i,
  input logic                   done_o,
  input logic [N_WIRES*Q_W-1:0] q_acc_o,
  input logic [N_WIRES*Q_W-1:0] q_col_o
);
  logic [15:0] cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cyc <= '0;
    else if (start_i && !busy_i) cyc <= '0;
    else if (busy_i)             cyc <= cyc + 16'd1;
  end

  p_done_not_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_i));

  p_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (cyc == 16'(2 * N_WIRES)));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(q_acc_o) && $stable(q_col_o)));

  p_accept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i) |=> (busy_i && !done_o));

  generate
    for (genvar w = 0; w < N_WIRES; w++) begin : g_w
      p_zero_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i |=> ((q_acc_o[w*Q_W +: Q_W] == $past(q_acc_o[w*Q_W +: Q_W])) ||
                    (q_acc_o[w*Q_W +: Q_W] == '0)) &&
                   ((q_col_o[w*Q_W +: Q_W] == $past(q_col_o[w*Q_W +: Q_W])) ||
                    (q_col_o[w*Q_W +: Q_W] == '0)));
    end
  endgenerate
endmodule

bind ghost_cancel gc_chk #(.N_WIRES(N_WIRES), .Q_W(Q_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_i  (busy),
  .done_o  (done_o),
  .q_acc_o (q_acc_o),
  .q_col_o (q_col_o)
);

// File: tb/ghost_cancel_test.sv
module ghost_cancel_test;
  localparam int  N    = 8;
  localparam int  QW   = 3;
  localparam int  BW   = 4;
  localparam time TCLK = 10ns;

  typedef struct packed {
    logic [N*QW-1:0] qa;
    logic [N*QW-1:0] qc;
    logic [N*BW-1:0] bx;
    logic [BW-1:0]   dep;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{24'o55_31_64_27, 24'o01_23_45_67, 32'h0000_0000, 4'd0},
    '{24'o77_77_77_77, 24'o10_10_10_10, 32'h0123_4567, 4'd1},
    '{24'o03_03_03_03, 24'o66_00_66_00, 32'h0000_0000, 4'd15},
    '{24'o12_34_56_71, 24'o75_31_13_57, 32'h2222_5555, 4'd3},
    '{24'o40_04_40_04, 24'o22_33_22_33, 32'h9182_7364, 4'd5},
    '{24'o76_54_32_10, 24'o44_44_44_44, 32'hFEDC_BA98, 4'd2}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [BW-1:0] depth = '0;
  logic [N*QW-1:0] qa = '0, qc = '0;
  logic [N*BW-1:0] bx = '0;
  logic [N*QW-1:0] qa_o, qc_o, qa_oc, qc_oc;
  logic            done, done_c;

  int checks = 0;
  int errors = 0;
  int tick   = 0;

  always #(TCLK/2) clk = ~clk;

  ghost_cancel uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .depth_i(depth),
    .q_acc_i(qa), .q_col_i(qc), .bx_i(bx),
    .q_acc_o(qa_o), .q_col_o(qc_o), .done_o(done)
  );

  ghost_cancel #(.COMPACT(1'b1)) uut_c (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .depth_i(depth),
    .q_acc_i(qa), .q_col_i(qc), .bx_i(bx),
    .q_acc_o(qa_oc), .q_col_o(qc_oc), .done_o(done_c)
  );

  function automatic logic [N*QW-1:0] put(int w, int v);
    return (N*QW)'(v) << (w*QW);
  endfunction

  function automatic logic [N*BW-1:0] putb(int w, int v);
    return (N*BW)'(v) << (w*BW);
  endfunction

  function automatic logic [N*QW-1:0] model(logic [N*QW-1:0] q, logic [N*BW-1:0] b,
                                            logic [BW-1:0] d, bit cmp);
    logic [N*QW-1:0] r;
    r = q;
    for (int k = 0; k < N; k++) begin
      int cur, cb, pq, nq, pb, nb, pm, nm;
      bit kill;
      cur = int'(q[k*QW +: QW]);
      cb  = int'(b[k*BW +: BW]);
      pq  = (k > 0)   ? int'(q[(k-1)*QW +: QW]) : 0;
      nq  = (k < N-1) ? int'(q[(k+1)*QW +: QW]) : 0;
      pb  = (k > 0)   ? int'(b[(k-1)*BW +: BW]) : 0;
      nb  = (k < N-1) ? int'(b[(k+1)*BW +: BW]) : 0;
      pm  = cmp ? (pq & 3) : pq;
      nm  = cmp ? (nq & 3) : nq;
      kill = 1'b0;
      if (cur > 0) begin
        if (pq > 0 && (cb > pb ? cb - pb : pb - cb) <= int'(d))
          if (cmp ? (pm > cur) : (pm >= cur)) kill = 1'b1;
        if (nq > 0 && (cb > nb ? cb - nb : nb - cb) <= int'(d))
          if (cmp ? (nm >= cur) : (nm > cur)) kill = 1'b1;
      end
      if (kill) r[k*QW +: QW] = '0;
    end
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic launch(logic [N*QW-1:0] a, logic [N*QW-1:0] c,
                        logic [N*BW-1:0] b, logic [BW-1:0] d);
    @(negedge clk);
    qa = a; qc = c; bx = b; depth = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // returns falling edges seen after the accepting edge until done
  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run(string req, logic [N*QW-1:0] a, logic [N*QW-1:0] c,
                     logic [N*BW-1:0] b, logic [BW-1:0] d,
                     logic [N*QW-1:0] ea, logic [N*QW-1:0] ec,
                     logic [N*QW-1:0] eac, logic [N*QW-1:0] ecc);
    int n;
    launch(a, c, b, d);
    wait_done(n);
    chk({req, " R9 latency"}, 32'(n), 32'(2*N));
    chk({req, " acc"}, 32'(qa_o), 32'(ea));
    chk({req, " col"}, 32'(qc_o), 32'(ec));
    chk({req, " R8 acc compact"}, 32'(qa_oc), 32'(eac));
    chk({req, " R8 col compact"}, 32'(qc_oc), 32'(ecc));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      tick++;
      if (tick > 20000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected below 20000 cycles", tick);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int n;
    logic [N*QW-1:0] hold_a;
    repeat (3) @(negedge clk);
    chk("R1 acc reset", 32'(qa_o), 32'd0);
    chk("R1 col reset", 32'(qc_o), 32'd0);
    chk("R1 done reset", 32'(done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run("R2 R3 R7 table", VECS[i].qa, VECS[i].qc, VECS[i].bx, VECS[i].dep,
          model(VECS[i].qa, VECS[i].bx, VECS[i].dep, 1'b0),
          model(VECS[i].qc, VECS[i].bx, VECS[i].dep, 1'b0),
          model(VECS[i].qa, VECS[i].bx, VECS[i].dep, 1'b1),
          model(VECS[i].qc, VECS[i].bx, VECS[i].dep, 1'b1));
    end

    // R2 lower tie wins
    run("R2 tie", put(2,5)|put(3,5), '0, '0, 4'd0,
        put(2,5), '0, put(2,5)|put(3,5), '0);
    // R3 upper must be strictly better
    run("R3 upper", put(2,3)|put(3,5), '0, '0, 4'd0,
        put(3,5), '0, put(2,3)|put(3,5), '0);
    // R5 a cancelled wire still cancels
    run("R5 chain", put(1,6)|put(2,6)|put(3,6), '0, '0, 4'd0,
        put(1,6), '0, put(1,6)|put(2,6)|put(3,6), '0);
    run("R5 peak", put(1,4)|put(2,6)|put(3,4), '0, '0, 4'd0,
        put(2,6), '0, put(1,4)|put(2,6)|put(3,4), '0);
    // R7 depth window
    run("R7 outside", put(2,5)|put(3,5), '0, putb(3,3), 4'd2,
        put(2,5)|put(3,5), '0, put(2,5)|put(3,5), '0);
    run("R7 edge", put(2,5)|put(3,5), '0, putb(3,3), 4'd3,
        put(2,5), '0, put(2,5)|put(3,5), '0);
    // R8 compact mirrored tie
    run("R8 mirror", put(2,3)|put(3,3), '0, '0, 4'd0,
        put(2,3), '0, put(3,3), '0);
    // R6 classes do not interact
    run("R6 split", put(2,5), put(3,7), '0, 4'd0,
        put(2,5), put(3,7), put(2,5), put(3,7));
    // R4 edges and zero gaps
    run("R4 edge", put(0,2)|put(1,1)|put(3,2)|put(5,2)|put(7,3), '0, '0, 4'd0,
        put(0,2)|put(3,2)|put(5,2)|put(7,3), '0,
        put(0,2)|put(3,2)|put(5,2)|put(7,3), '0);

    // R9 result held after done
    hold_a = qa_o;
    repeat (4) @(negedge clk);
    chk("R9 done held", 32'(done), 32'd1);
    chk("R9 acc held", 32'(qa_o), 32'(hold_a));

    // R10 start during a run is ignored
    launch(put(2,5)|put(3,5), '0, '0, 4'd0);
    repeat (3) @(negedge clk);
    qa = put(4,7); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(n);
    chk("R10 latency", 32'(n + 4), 32'(2*N));
    chk("R10 result", 32'(qa_o), 32'(put(2,5)));
    @(negedge clk);
    chk("R10 stays done", 32'(done), 32'd1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule